// File: doc/BRIEF.md
# Chroma 4:2:2 to 4:4:4 Upsampler

This block takes a YCbCr pixel stream in which luma comes with every pixel, while only one chroma sample comes per pixel. The chroma alternates between a blue-difference and a red-difference sample. The block rebuilds a stream that carries luma, Cb and Cr on every pixel. Each line starts at the rising edge of the data-enable input. The first pixel of a line carries Cb, and the pixel after it carries the matching Cr. Together the two samples form a pair that is co-sited with the even pixel.

The odd pixel between two pairs needs its chroma filled in, and a per-line mode bit chooses how. In hold mode the odd pixel takes the chroma of its own pair. In interpolation mode it takes the rounded mean of its own pair and the following pair. When the source already delivers full chroma, the bypass bit hands every sample through untouched. Data enable, valid and both syncs travel alongside the pixels with a fixed delay that is the same in every mode, so the sink sees the framing aligned with the data.

Top module: `chroma_upsampler`

## Requirements
- R1: While reset is asserted, and on the first clock after it, outValid, outDe, outHsync, outVsync, outY, outCb and outCr are all zero.
- R2: outValid, outDe, outHsync and outVsync equal inValid, inDe, inHsync and inVsync from 4 clocks earlier, in every mode.
- R3: For an even pixel (index 0, 2, 4 … counted from the line start) whose following pixel is in the same line, outCb is that pixel's own inCb and outCr is the inCb of the following pixel.
- R4: With cfgInterp = 0 (hold mode), an odd pixel repeats the Cb and Cr of the pair that begins at the pixel before it.
- R5: With cfgInterp = 1, an odd pixel k gets outCb = (Cb(k-1)+Cb(k+1)+1)>>1 and outCr = (Cr(k)+Cr(k+2)+1)>>1, computed without overflow. Here Cb(j) and Cr(j) are the inCb sample of pixel j. This applies when pixels k+1 and k+2 are both in the line.
- R6: Line end. An odd pixel whose next pair is not complete in the line falls back to repeating its own pair, even in interpolation mode. An even pixel with no following pixel outputs its own inCb on both outCb and outCr.
- R7: Pixel parity restarts at every rising edge of inDe, so a line that follows a line of odd length still begins with a Cb sample, even when the two lines are separated by a single cycle of low inDe.
- R8: cfgInterp and cfgBypass are sampled only on the cycle in which inDe rises. A change of either during a line does not alter that line's output.
- R9: In a line that starts with cfgBypass = 1, outY, outCb and outCr equal inY, inCb and inCr of the same pixel.
- R10: On a cycle that is not a pixel (inDe = 0 or inValid = 0), outCb and outCr carry the raw inCb and inCr of that cycle.
- R11: outY always equals the inY of the same sample, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Marks a sample slot as carrying data |
| inDe | input | 1 | Active-video enable. A rising edge starts a line. |
| inHsync | input | 1 | Horizontal sync, delayed to the output |
| inVsync | input | 1 | Vertical sync, delayed to the output |
| inY | input | DATA_W | Luma sample |
| inCb | input | DATA_W | Alternating Cb/Cr chroma sample, or Cb in bypass |
| inCr | input | DATA_W | Cr in bypass. Used only in bypass and blanking. |
| cfgInterp | input | 1 | 0 = hold, 1 = linear interpolation. Sampled at line start. |
| cfgBypass | input | 1 | 1 = pass all components through. Sampled at line start. |
| outValid | output | 1 | Delayed inValid |
| outDe | output | 1 | Delayed inDe |
| outHsync | output | 1 | Delayed inHsync |
| outVsync | output | 1 | Delayed inVsync |
| outY | output | DATA_W | Delayed luma |
| outCb | output | DATA_W | Reconstructed Cb |
| outCr | output | DATA_W | Reconstructed Cr |

## Verification
The assertions assume that inValid stays high on every cycle in which inDe is high. Under that assumption pixel parity and the lookahead window count clock cycles and pixels alike. The hold-mode property relies on this to treat the previous output cycle as the even pixel of the same pair. The latency properties also take for granted that at least four clocks have passed since reset before they compare against delayed inputs. The bench drives inValid high throughout every active line and toggles it only in blanking. It separates lines by at least one low inDe cycle, and it changes the configuration bits only at negative clock edges, away from the sampling edge.

// File: rtl/chroma_up_pkg.sv
package chroma_up_pkg;

  // Number of input samples held in the lookahead window. The pixel being
  // reconstructed sits at the oldest slot and its two successors follow it.
  localparam int WIN_DEPTH = 3;
  localparam int OLDEST    = WIN_DEPTH - 1;
  localparam int NEXT1     = WIN_DEPTH - 2;
  localparam int NEXT2     = WIN_DEPTH - 3;

  // Framing and per-line attributes carried with every sample.
  typedef struct packed {
    logic valid;
    logic de;
    logic hs;
    logic vs;
    logic pixel;   // valid and inside active video
    logic odd;     // parity inside the line
    logic start;   // first pixel of a line
    logic interp;  // line mode latched at line start
    logic bypass;  // line bypass latched at line start
  } stageCtl_t;

  // Strobes from control to datapath for the pixel at the oldest slot.
  typedef struct packed {
    logic pixel;
    logic odd;
    logic interp;
    logic bypass;
    logic haveRight;  // immediate successor is in the same line
    logic haveNext;   // both samples of the next pair are in the line
    logic captureCb;  // store this pixel's chroma as the pair's Cb
  } dpStrobe_t;

endpackage

// File: rtl/chroma_up_avg.sv
module chroma_up_avg #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] mean
);

  localparam int SUM_W = DATA_W + 1;

  logic [SUM_W-1:0] sum;

  // One extra bit absorbs the carry; adding one before the shift rounds half up.
  assign sum  = SUM_W'(a) + SUM_W'(b) + SUM_W'(1);
  assign mean = sum[SUM_W-1:1];

endmodule

// File: rtl/chroma_up_ctrl.sv
module chroma_up_ctrl
  import chroma_up_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inDe,
  input  logic      inHsync,
  input  logic      inVsync,
  input  logic      cfgInterp,
  input  logic      cfgBypass,
  output dpStrobe_t strobe,
  output logic      outValid,
  output logic      outDe,
  output logic      outHsync,
  output logic      outVsync
);

  logic      prevDe;
  logic      nextOdd;
  logic      lineInterp;
  logic      lineBypass;
  logic      deRise;
  stageCtl_t incoming;
  stageCtl_t win [WIN_DEPTH];

  assign deRise = inDe && !prevDe;

  always_comb begin
    incoming.valid  = inValid;
    incoming.de     = inDe;
    incoming.hs     = inHsync;
    incoming.vs     = inVsync;
    incoming.pixel  = inValid && inDe;
    incoming.odd    = deRise ? 1'b0 : nextOdd;
    incoming.start  = deRise;
    incoming.interp = deRise ? cfgInterp : lineInterp;
    incoming.bypass = deRise ? cfgBypass : lineBypass;
  end

  // Line tracking: parity and the configuration captured at line start.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevDe     <= 1'b0;
      nextOdd    <= 1'b0;
      lineInterp <= 1'b0;
      lineBypass <= 1'b0;
    end else begin
      prevDe <= inDe;
      if (deRise) begin
        lineInterp <= cfgInterp;
        lineBypass <= cfgBypass;
      end
      if (incoming.pixel) begin
        nextOdd <= ~incoming.odd;
      end
    end
  end

  // Lookahead window of control attributes.
  for (genvar g = 0; g < WIN_DEPTH; g++) begin : g_win
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) win[g] <= '0;
        else       win[g] <= incoming;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) win[g] <= '0;
        else       win[g] <= win[g-1];
      end
    end
  end

  function automatic logic sameLine(stageCtl_t s);
    return s.pixel && !s.start;
  endfunction

  always_comb begin
    strobe.pixel     = win[OLDEST].pixel;
    strobe.odd       = win[OLDEST].odd;
    strobe.interp    = win[OLDEST].interp;
    strobe.bypass    = win[OLDEST].bypass;
    strobe.haveRight = sameLine(win[NEXT1]);
    strobe.haveNext  = sameLine(win[NEXT1]) && sameLine(win[NEXT2]);
    strobe.captureCb = win[OLDEST].pixel && !win[OLDEST].odd && !win[OLDEST].bypass;
  end

  // Output framing register, aligned with the datapath output register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outDe    <= 1'b0;
      outHsync <= 1'b0;
      outVsync <= 1'b0;
    end else begin
      outValid <= win[OLDEST].valid;
      outDe    <= win[OLDEST].de;
      outHsync <= win[OLDEST].hs;
      outVsync <= win[OLDEST].vs;
    end
  end

endmodule

// File: rtl/chroma_up_datapath.sv
module chroma_up_datapath
  import chroma_up_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inY,
  input  logic [DATA_W-1:0] inCb,
  input  logic [DATA_W-1:0] inCr,
  input  dpStrobe_t         strobe,
  output logic [DATA_W-1:0] outY,
  output logic [DATA_W-1:0] outCb,
  output logic [DATA_W-1:0] outCr
);

  logic [DATA_W-1:0] wY  [WIN_DEPTH];
  logic [DATA_W-1:0] wCb [WIN_DEPTH];
  logic [DATA_W-1:0] wCr [WIN_DEPTH];
  logic [DATA_W-1:0] holdCb;
  logic [DATA_W-1:0] meanCb;
  logic [DATA_W-1:0] meanCr;
  logic [DATA_W-1:0] nextCb;
  logic [DATA_W-1:0] nextCr;

  for (genvar g = 0; g < WIN_DEPTH; g++) begin : g_win
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          wY[g] <= '0; wCb[g] <= '0; wCr[g] <= '0;
        end else begin
          wY[g] <= inY; wCb[g] <= inCb; wCr[g] <= inCr;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          wY[g] <= '0; wCb[g] <= '0; wCr[g] <= '0;
        end else begin
          wY[g] <= wY[g-1]; wCb[g] <= wCb[g-1]; wCr[g] <= wCr[g-1];
        end
      end
    end
  end

  // Cb of the current pair survives one slot beyond the window.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 holdCb <= '0;
    else if (strobe.captureCb) holdCb <= wCb[OLDEST];
  end

  chroma_up_avg #(.DATA_W(DATA_W)) u_avgCb (
    .a(holdCb), .b(wCb[NEXT1]), .mean(meanCb)
  );

  chroma_up_avg #(.DATA_W(DATA_W)) u_avgCr (
    .a(wCb[OLDEST]), .b(wCb[NEXT2]), .mean(meanCr)
  );

  always_comb begin
    if (!strobe.pixel || strobe.bypass) begin
      nextCb = wCb[OLDEST];
      nextCr = wCr[OLDEST];
    end else if (!strobe.odd) begin
      nextCb = wCb[OLDEST];
      nextCr = strobe.haveRight ? wCb[NEXT1] : wCb[OLDEST];
    end else if (strobe.interp && strobe.haveNext) begin
      nextCb = meanCb;
      nextCr = meanCr;
    end else begin
      nextCb = holdCb;
      nextCr = wCb[OLDEST];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outY  <= '0;
      outCb <= '0;
      outCr <= '0;
    end else begin
      outY  <= wY[OLDEST];
      outCb <= nextCb;
      outCr <= nextCr;
    end
  end

endmodule

// File: rtl/chroma_upsampler.sv
module chroma_upsampler
  import chroma_up_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inDe,
  input  logic              inHsync,
  input  logic              inVsync,
  input  logic [DATA_W-1:0] inY,
  input  logic [DATA_W-1:0] inCb,
  input  logic [DATA_W-1:0] inCr,
  input  logic              cfgInterp,
  input  logic              cfgBypass,
  output logic              outValid,
  output logic              outDe,
  output logic              outHsync,
  output logic              outVsync,
  output logic [DATA_W-1:0] outY,
  output logic [DATA_W-1:0] outCb,
  output logic [DATA_W-1:0] outCr
);

  dpStrobe_t strobe;

  chroma_up_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inDe(inDe), .inHsync(inHsync), .inVsync(inVsync),
    .cfgInterp(cfgInterp), .cfgBypass(cfgBypass),
    .strobe(strobe),
    .outValid(outValid), .outDe(outDe), .outHsync(outHsync), .outVsync(outVsync)
  );

  chroma_up_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .inY(inY), .inCb(inCb), .inCr(inCr),
    .strobe(strobe),
    .outY(outY), .outCb(outCb), .outCr(outCr)
  );

endmodule

// File: rtl/chroma_up_checker.sv
module chroma_up_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inDe,
  input logic              inHsync,
  input logic              inVsync,
  input logic [DATA_W-1:0] inY,
  input logic [DATA_W-1:0] inCb,
  input logic [DATA_W-1:0] inCr,
  input logic              cfgInterp,
  input logic              cfgBypass,
  input logic              outValid,
  input logic              outDe,
  input logic              outHsync,
  input logic              outVsync,
  input logic [DATA_W-1:0] outY,
  input logic [DATA_W-1:0] outCb,
  input logic [DATA_W-1:0] outCr
);

  logic [2:0] seen;
  logic [3:0] dInterp;
  logic [3:0] dBypass;
  logic       outDePrev;
  logic       oddNext;
  logic       lineInterp;
  logic       lineBypass;
  logic       outRise;
  logic       curOdd;
  logic       curInterp;
  logic       curBypass;

  assign outRise   = outDe && !outDePrev;
  assign curOdd    = outRise ? 1'b0 : oddNext;
  assign curInterp = outRise ? dInterp[3] : lineInterp;
  assign curBypass = outRise ? dBypass[3] : lineBypass;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen       <= '0;
      dInterp    <= '0;
      dBypass    <= '0;
      outDePrev  <= 1'b0;
      oddNext    <= 1'b0;
      lineInterp <= 1'b0;
      lineBypass <= 1'b0;
    end else begin
      if (seen != 3'd4) seen <= seen + 3'd1;
      dInterp   <= {dInterp[2:0], cfgInterp};
      dBypass   <= {dBypass[2:0], cfgBypass};
      outDePrev <= outDe;
      if (outRise) begin
        lineInterp <= dInterp[3];
        lineBypass <= dBypass[3];
      end
      if (outDe && outValid) oddNext <= ~curOdd;
    end
  end

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!outValid && !outDe && !outHsync && !outVsync &&
               outY == '0 && outCb == '0 && outCr == '0));

  // R2
  p_frame_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    (seen == 3'd4) |-> (outDe == $past(inDe, 4) && outValid == $past(inValid, 4) &&
                        outHsync == $past(inHsync, 4) && outVsync == $past(inVsync, 4)));

  // R11
  p_luma_delay_r11: assert property (@(posedge clk) disable iff (!rstN)
    (seen == 3'd4) |-> (outY == $past(inY, 4)));

  // R10
  p_blank_raw_r10: assert property (@(posedge clk) disable iff (!rstN)
    (seen == 3'd4 && !outDe) |-> (outCb == $past(inCb, 4) && outCr == $past(inCr, 4)));

  // R4
  p_hold_repeat_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outDe && outValid && curOdd && !curInterp && !curBypass) |->
      (outCb == $past(outCb) && outCr == $past(outCr)));

endmodule

bind chroma_upsampler chroma_up_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .inValid(inValid), .inDe(inDe), .inHsync(inHsync), .inVsync(inVsync),
  .inY(inY), .inCb(inCb), .inCr(inCr),
  .cfgInterp(cfgInterp), .cfgBypass(cfgBypass),
  .outValid(outValid), .outDe(outDe), .outHsync(outHsync), .outVsync(outVsync),
  .outY(outY), .outCb(outCb), .outCr(outCr)
);

// File: tb/sim_chroma_upsampler.sv
module sim_chroma_upsampler;

  localparam int MAX_SLOTS = 4096;
  localparam int LAT       = 4;

  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid, inDe, inHsync, inVsync;
  logic [7:0] inY, inCb, inCr;
  logic       cfgInterp, cfgBypass;
  logic       outValid, outDe, outHsync, outVsync;
  logic [7:0] outY, outCb, outCr;

  chroma_upsampler #(.DATA_W(8)) u0 (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inDe(inDe), .inHsync(inHsync), .inVsync(inVsync),
    .inY(inY), .inCb(inCb), .inCr(inCr),
    .cfgInterp(cfgInterp), .cfgBypass(cfgBypass),
    .outValid(outValid), .outDe(outDe), .outHsync(outHsync), .outVsync(outVsync),
    .outY(outY), .outCb(outCb), .outCr(outCr)
  );

  always #10 clk = ~clk;

  int passCnt = 0;
  int failCnt = 0;
  int slot    = 0;

  logic [3:0] eFrame [MAX_SLOTS];
  logic [7:0] eY     [MAX_SLOTS];
  logic [7:0] eCb    [MAX_SLOTS];
  logic [7:0] eCr    [MAX_SLOTS];
  string      eTag   [MAX_SLOTS];

  int lineY [64];
  int lineC [64];
  int lineR [64];

  task automatic checkSlot(input int s);
    if ({outValid, outDe, outHsync, outVsync} !== eFrame[s] ||
        outY !== eY[s] || outCb !== eCb[s] || outCr !== eCr[s]) begin
      failCnt++;
      $display("FAIL %s (framing R2, luma R11) slot %0d: got vdhs=%b y=%h cb=%h cr=%h, expected vdhs=%b y=%h cb=%h cr=%h",
               eTag[s], s, {outValid, outDe, outHsync, outVsync}, outY, outCb, outCr,
               eFrame[s], eY[s], eCb[s], eCr[s]);
    end else begin
      passCnt++;
    end
  endtask

  // One sample slot: check the output due now, then drive the next input.
  task automatic step(input logic v, input logic de, input logic hs, input logic vs,
                      input int y, input int cb, input int cr,
                      input int expCb, input int expCr, input string tag);
    @(negedge clk);
    if (slot >= LAT) checkSlot(slot - LAT);
    inValid = v; inDe = de; inHsync = hs; inVsync = vs;
    inY = 8'(y); inCb = 8'(cb); inCr = 8'(cr);
    eFrame[slot] = {v, de, hs, vs};
    eY[slot]     = 8'(y);
    eCb[slot]    = 8'(expCb);
    eCr[slot]    = 8'(expCr);
    eTag[slot]   = tag;
    slot++;
  endtask

  // Blanking: raw chroma must pass (R10), valid toggles, sync pulses.
  task automatic blank(input int n, input logic vs);
    for (int i = 0; i < n; i++) begin
      int cb = (i * 53 + 17) & 255;
      int cr = (i * 91 + 3) & 255;
      step(i[0], 1'b0, i < 2, vs, (i * 13 + 5) & 255, cb, cr, cb, cr, "R10");
    end
  endtask

  // Drives one line from lineY/lineC/lineR. The mode flips after pixel toggleAt.
  task automatic runLine(input int n, input logic interp, input logic bypass,
                         input int toggleAt, input string label);
    cfgInterp = interp;
    cfgBypass = bypass;
    for (int k = 0; k < n; k++) begin
      int ecb, ecr;
      string tag;
      if (bypass) begin
        ecb = lineC[k]; ecr = lineR[k]; tag = "R9";
      end else if (k % 2 == 0) begin
        ecb = lineC[k];
        ecr = (k + 1 < n) ? lineC[k+1] : lineC[k];
        tag = (k + 1 < n) ? ((k == 0) ? "R7/R3" : "R3") : "R6";
      end else if (interp && k + 2 < n) begin
        ecb = (lineC[k-1] + lineC[k+1] + 1) / 2;
        ecr = (lineC[k] + lineC[k+2] + 1) / 2;
        tag = "R5";
      end else begin
        ecb = lineC[k-1]; ecr = lineC[k];
        tag = interp ? "R6" : "R4";
      end
      if (toggleAt >= 0 && k > toggleAt) tag = {"R8 ", tag};
      step(1'b1, 1'b1, 1'b0, 1'b0, lineY[k], lineC[k], lineR[k], ecb, ecr, {label, " ", tag});
      if (k == toggleAt) begin
        cfgInterp = ~interp;
        cfgBypass = ~bypass;
      end
    end
  endtask

  task automatic fillRamp(input int n, input int seed);
    for (int k = 0; k < n; k++) begin
      lineY[k] = (seed + k * 7) & 255;
      lineC[k] = (seed * 3 + k * 29) & 255;
      lineR[k] = (seed * 5 + k * 61 + 9) & 255;
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    inValid = 1'b1; inDe = 1'b1; inHsync = 1'b1; inVsync = 1'b1;
    inY = 8'hA5; inCb = 8'h5A; inCr = 8'h3C;
    cfgInterp = 1'b0; cfgBypass = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      if ({outValid, outDe, outHsync, outVsync} !== 4'b0 || outY !== 8'h0 ||
          outCb !== 8'h0 || outCr !== 8'h0) begin
        failCnt++;
        $display("FAIL R1 reset: got vdhs=%b y=%h cb=%h cr=%h, expected all zero",
                 {outValid, outDe, outHsync, outVsync}, outY, outCb, outCr);
      end else begin
        passCnt++;
      end
    end
    inValid = 1'b0; inDe = 1'b0; inHsync = 1'b0; inVsync = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testHold();        // R3, R4
    blank(4, 1'b1);
    fillRamp(8, 11);
    runLine(8, 1'b0, 1'b0, -1, "hold");
    blank(6, 1'b0);
  endtask

  task automatic testInterp();      // R5, R6
    fillRamp(10, 40);
    runLine(10, 1'b1, 1'b0, -1, "interp");
    blank(6, 1'b0);
  endtask

  task automatic testRounding();    // R5 carry and rounding at the range ends
    for (int k = 0; k < 12; k++) begin
      lineY[k] = 255 - k;
      lineC[k] = (k % 4 < 2) ? 255 - (k % 3) : k % 3;
      lineR[k] = k * 17;
    end
    lineC[2] = 254; lineC[3] = 253;
    runLine(12, 1'b1, 1'b0, -1, "round");
    blank(6, 1'b0);
  endtask

  task automatic testMidLineToggle(); // R8
    fillRamp(8, 77);
    runLine(8, 1'b0, 1'b0, 2, "toggleHold");
    blank(5, 1'b0);
    fillRamp(10, 123);
    runLine(10, 1'b1, 1'b0, 1, "toggleInterp");
    blank(6, 1'b0);
  endtask

  task automatic testBypass();      // R9
    fillRamp(6, 200);
    runLine(6, 1'b0, 1'b1, -1, "bypass");
    blank(5, 1'b0);
    fillRamp(6, 201);
    runLine(6, 1'b1, 1'b1, -1, "bypassInterp");
    blank(6, 1'b0);
  endtask

  task automatic testOddLineBackToBack(); // R6, R7
    fillRamp(5, 9);
    runLine(5, 1'b1, 1'b0, -1, "oddLine");
    blank(1, 1'b0);
    fillRamp(8, 150);
    runLine(8, 1'b1, 1'b0, -1, "afterOdd");
    blank(1, 1'b0);
    fillRamp(3, 60);
    runLine(3, 1'b0, 1'b0, -1, "shortHold");
    blank(6, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

  initial begin
    testReset();
    testHold();
    testInterp();
    testRounding();
    testMidLineToggle();
    testBypass();
    testOddLineBackToBack();
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

endmodule